// File: doc/BRIEF.md
# Processor-Driven March Element Engine

This block lets an on-chip processor test a synchronous RAM with a March algorithm that lives in software. The processor sets up a small register window over a simple write/read bus. It writes a data background, a lower and an upper address bound, and a code that picks one March element and its address direction. It then writes a start command and polls a status register. The engine sweeps the selected address range and issues the element's read and write operations to the RAM, one operation per clock. Each read is compared against the background word or its bitwise inverse.

On the first mismatch the engine stops. It keeps the failing address and the data that was read, and the status register shows a failure code. If the sweep completes without a mismatch, the status shows a pass code. A complete March C- test is six start commands, each followed by a poll, so the algorithm's order and length stay under software control. The hardware only knows how to run a single element.

Top module: `march_engine`

## Requirements
- R1: After reset the status register reads 0x00, all configuration registers read 0 and `mem_en` is low.
- R2: The register window uses these word offsets on `bus_addr`: 0 background, 1 lower bound, 2 upper bound, 3 element code, 4 command (write only), 5 status, 6 failing address, 7 failing data. Offsets 0 to 3 read back what was last written, zero-extended.
- R3: In the element code, bits [1:0] pick the operations: 0 = write "0"; 1 = read "0" then write "1"; 2 = read "1" then write "0"; 3 = read "0". A "0" stands for the background word and a "1" for its bitwise inverse (background 0x55 gives 0xAA).
- R4: Each operation takes exactly one cycle with `mem_en` high. Both operations of a read/write pair go to the same address before the address steps. A clean element over N addresses issues N or 2N operations and no others.
- R5: Read data returned in the cycle after a read is compared with the expected word. On the first mismatch the status becomes 0x01, the failing address and data are captured, and no further operation is issued after the one in flight in that cycle.
- R6: When the last operation completes with no mismatch, the status reads 0xFF two clock edges after the edge that issued that operation.
- R7: From the start command until the element ends, the status reads 0x0F.
- R8: Writing a value with bit 0 set to offset 4 while the engine is idle starts an element. This clears the status and both failure registers. While the engine is busy, writes to any offset are ignored.
- R9: Element code bit 2 selects the direction. With 0 the sweep runs from the lower bound up to the upper bound. With 1 it runs from the upper bound down to the lower bound. The range includes both bounds, and the lower bound must not exceed the upper bound.
- R10: `mem_we` is high only together with `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data (combinational from `bus_addr`) |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after a read |

## Verification
The checker watches properties on every cycle. It checks that writes occur only together with enables and that addresses stay inside the bounds. It checks that each step moves by one address in the coded direction and that a read in a pair is followed by a write to the same address. It also checks that the configuration stays frozen while the engine is busy, that the status reads busy throughout a run, and that no access follows a failure or a pass. Only the bench's scenarios can show the rest. These are the exact operation stream of each element, the expected data of inverse reads, and the cycle count to the final status. They also include the captured address and data of an injected stuck bit, clearing on restart, and that commands written mid-run have no effect.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [1:0] {
        EL_W0   = 2'd0,
        EL_R0W1 = 2'd1,
        EL_R1W0 = 2'd2,
        EL_R0   = 2'd3
    } elem_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_DRAIN = 2'd2
    } seq_e;

    localparam int unsigned REG_AW = 3;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned STS_W  = 8;

    localparam logic [REG_AW-1:0] RA_BG     = 3'd0;
    localparam logic [REG_AW-1:0] RA_LO     = 3'd1;
    localparam logic [REG_AW-1:0] RA_HI     = 3'd2;
    localparam logic [REG_AW-1:0] RA_CODE   = 3'd3;
    localparam logic [REG_AW-1:0] RA_CMD    = 3'd4;
    localparam logic [REG_AW-1:0] RA_STATUS = 3'd5;
    localparam logic [REG_AW-1:0] RA_FADDR  = 3'd6;
    localparam logic [REG_AW-1:0] RA_FDATA  = 3'd7;

    localparam logic [STS_W-1:0] STS_IDLE = 8'h00;
    localparam logic [STS_W-1:0] STS_BUSY = 8'h0F;
    localparam logic [STS_W-1:0] STS_FAIL = 8'h01;
    localparam logic [STS_W-1:0] STS_PASS = 8'hFF;

    function automatic logic elem_is_pair(elem_e e);
        return (e == EL_R0W1) || (e == EL_R1W0);
    endfunction

    // operation of element e in phase ph: returns {is_write, use_inverse}
    function automatic logic [1:0] elem_op(elem_e e, logic ph);
        logic [1:0] r;
        case (e)
            EL_W0:   r = 2'b10;
            EL_R0W1: r = ph ? 2'b11 : 2'b00;
            EL_R1W0: r = ph ? 2'b10 : 2'b01;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/march_regs.sv
module march_regs
    import march_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic [STS_W-1:0]  status,
    input  logic [ADDR_W-1:0] fail_addr,
    input  logic [DATA_W-1:0] fail_data,
    output logic [DATA_W-1:0] cfg_bg,
    output logic [ADDR_W-1:0] cfg_lo,
    output logic [ADDR_W-1:0] cfg_hi,
    output logic [CODE_W-1:0] cfg_code,
    output logic              go
);

    typedef struct packed {
        logic [DATA_W-1:0] bg;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [CODE_W-1:0] code;
    } cfg_t;

    cfg_t c_d, c_q;

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata;

    always_comb begin
        c_d = c_q;
        go  = 1'b0;
        if (bus_wr && !busy) begin
            case (bus_addr)
                RA_BG:   c_d.bg   = bus_wdata[DATA_W-1:0];
                RA_LO:   c_d.lo   = bus_wdata[ADDR_W-1:0];
                RA_HI:   c_d.hi   = bus_wdata[ADDR_W-1:0];
                RA_CODE: c_d.code = bus_wdata[CODE_W-1:0];
                RA_CMD:  go       = bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            RA_BG:     bus_rdata = BUS_W'(c_q.bg);
            RA_LO:     bus_rdata = BUS_W'(c_q.lo);
            RA_HI:     bus_rdata = BUS_W'(c_q.hi);
            RA_CODE:   bus_rdata = BUS_W'(c_q.code);
            RA_STATUS: bus_rdata = BUS_W'(status);
            RA_FADDR:  bus_rdata = BUS_W'(fail_addr);
            RA_FDATA:  bus_rdata = BUS_W'(fail_data);
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cfg_bg   = c_q.bg;
    assign cfg_lo   = c_q.lo;
    assign cfg_hi   = c_q.hi;
    assign cfg_code = c_q.code;

endmodule

// File: rtl/march_seq.sv
module march_seq
    import march_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              halt,
    input  logic [DATA_W-1:0] cfg_bg,
    input  logic [ADDR_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] cfg_hi,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              chk_vld,
    output logic [ADDR_W-1:0] chk_addr,
    output logic [DATA_W-1:0] chk_exp,
    output logic              busy,
    output logic              finish
);

    typedef struct packed {
        seq_e              st;
        logic [ADDR_W-1:0] addr;
        logic              ph;
        logic              vld;
        logic [ADDR_W-1:0] caddr;
        logic [DATA_W-1:0] cexp;
    } seq_t;

    seq_t s_d, s_q;

    elem_e             elem;
    logic              down;
    logic              pair;
    logic [1:0]        op;
    logic [DATA_W-1:0] cur_data;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] last_addr;
    logic              step_now;

    always_comb begin
        elem       = elem_e'(cfg_code[1:0]);
        down       = cfg_code[2];
        pair       = elem_is_pair(elem);
        op         = elem_op(elem, s_q.ph);
        cur_data   = op[0] ? ~cfg_bg : cfg_bg;
        first_addr = down ? cfg_hi : cfg_lo;
        last_addr  = down ? cfg_lo : cfg_hi;
        step_now   = !pair || s_q.ph;

        s_d     = s_q;
        s_d.vld = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (go) begin
                    s_d.st   = SQ_RUN;
                    s_d.addr = first_addr;
                    s_d.ph   = 1'b0;
                end
            end
            SQ_RUN: begin
                if (halt) begin
                    s_d.st = SQ_IDLE;
                end else begin
                    if (!op[1]) begin
                        s_d.vld   = 1'b1;
                        s_d.caddr = s_q.addr;
                        s_d.cexp  = cur_data;
                    end
                    if (pair) s_d.ph = !s_q.ph;
                    if (step_now) begin
                        if (s_q.addr == last_addr) s_d.st = SQ_DRAIN;
                        else if (down)             s_d.addr = s_q.addr - ADDR_W'(1);
                        else                       s_d.addr = s_q.addr + ADDR_W'(1);
                    end
                end
            end
            SQ_DRAIN: s_d.st = SQ_IDLE;
            default:  s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign mem_en    = (s_q.st == SQ_RUN);
    assign mem_we    = (s_q.st == SQ_RUN) && op[1];
    assign mem_addr  = s_q.addr;
    assign mem_wdata = cur_data;
    assign chk_vld   = s_q.vld;
    assign chk_addr  = s_q.caddr;
    assign chk_exp   = s_q.cexp;
    assign busy      = (s_q.st != SQ_IDLE);
    assign finish    = (s_q.st == SQ_DRAIN) && !halt;

endmodule

// File: rtl/march_cmp.sv
module march_cmp
    import march_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              chk_vld,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [DATA_W-1:0] chk_exp,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              finish,
    output logic              mismatch,
    output logic [STS_W-1:0]  status,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data
);

    typedef struct packed {
        logic [STS_W-1:0]  sts;
        logic [ADDR_W-1:0] faddr;
        logic [DATA_W-1:0] fdata;
    } cmp_t;

    cmp_t c_d, c_q;

    always_comb begin
        mismatch = chk_vld && (mem_rdata != chk_exp);
        c_d = c_q;
        if (go) begin
            c_d.sts   = STS_BUSY;
            c_d.faddr = '0;
            c_d.fdata = '0;
        end else if (mismatch) begin
            c_d.sts   = STS_FAIL;
            c_d.faddr = chk_addr;
            c_d.fdata = mem_rdata;
        end else if (finish) begin
            c_d.sts   = STS_PASS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{sts: STS_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign status    = c_q.sts;
    assign fail_addr = c_q.faddr;
    assign fail_data = c_q.fdata;

endmodule

// File: rtl/march_engine.sv
module march_engine
    import march_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              busy;
    logic              go;
    logic              mismatch;
    logic              finish;
    logic [STS_W-1:0]  status;
    logic [ADDR_W-1:0] fail_addr;
    logic [DATA_W-1:0] fail_data;
    logic [DATA_W-1:0] cfg_bg;
    logic [ADDR_W-1:0] cfg_lo;
    logic [ADDR_W-1:0] cfg_hi;
    logic [CODE_W-1:0] cfg_code;
    logic              chk_vld;
    logic [ADDR_W-1:0] chk_addr;
    logic [DATA_W-1:0] chk_exp;

    march_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .status    (status),
        .fail_addr (fail_addr),
        .fail_data (fail_data),
        .cfg_bg    (cfg_bg),
        .cfg_lo    (cfg_lo),
        .cfg_hi    (cfg_hi),
        .cfg_code  (cfg_code),
        .go        (go)
    );

    march_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .halt      (mismatch),
        .cfg_bg    (cfg_bg),
        .cfg_lo    (cfg_lo),
        .cfg_hi    (cfg_hi),
        .cfg_code  (cfg_code),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .chk_vld   (chk_vld),
        .chk_addr  (chk_addr),
        .chk_exp   (chk_exp),
        .busy      (busy),
        .finish    (finish)
    );

    march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .chk_vld   (chk_vld),
        .chk_addr  (chk_addr),
        .chk_exp   (chk_exp),
        .mem_rdata (mem_rdata),
        .finish    (finish),
        .mismatch  (mismatch),
        .status    (status),
        .fail_addr (fail_addr),
        .fail_data (fail_data)
    );

endmodule

// File: rtl/march_engine_chk.sv
module march_engine_chk
    import march_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] cfg_bg,
    input logic [ADDR_W-1:0] cfg_lo,
    input logic [ADDR_W-1:0] cfg_hi,
    input logic [CODE_W-1:0] cfg_code,
    input logic              busy,
    input logic [STS_W-1:0]  status
);

    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en); // R10

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && cfg_lo <= cfg_hi) |-> (mem_addr >= cfg_lo && mem_addr <= cfg_hi)); // R9

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en) && !cfg_code[2])
        |-> (mem_addr == $past(mem_addr) || mem_addr == $past(mem_addr) + ADDR_W'(1))); // R4

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en) && cfg_code[2])
        |-> (mem_addr == $past(mem_addr) || mem_addr == $past(mem_addr) - ADDR_W'(1))); // R9

    AST_PAIR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && (cfg_code[1:0] == 2'd1 || cfg_code[1:0] == 2'd2))
        |=> (mem_we && mem_addr == $past(mem_addr))); // R4

    AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STS_FAIL) |-> !mem_en); // R5

    AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STS_PASS) |-> !busy); // R6

    AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status == STS_BUSY)); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_bg) && $stable(cfg_code)
                                   && $stable(cfg_lo) && $stable(cfg_hi))); // R8

endmodule

bind march_engine march_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .cfg_bg   (cfg_bg),
    .cfg_lo   (cfg_lo),
    .cfg_hi   (cfg_hi),
    .cfg_code (cfg_code),
    .busy     (busy),
    .status   (status)
);

// File: tb/sim_march_engine.sv
module sim_march_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        mem_en;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    always #10 clk = ~clk;

    march_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
    } op_t;

    op_t        expq[$];
    int         n_chk  = 0;
    int         n_fail = 0;
    logic [7:0] ram  [256];
    logic [7:0] pmem [256];
    logic       flt_on;
    logic [7:0] flt_addr;
    logic [7:0] flt_mask;

    // RAM under test, with an optional stuck-at-1 read fault
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else mem_rdata <= ram[mem_addr] | ((flt_on && mem_addr == flt_addr) ? flt_mask : 8'h00);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard of RAM operations
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (mem_we) check(mem_en, "R10", "write without enable", {31'd0, mem_en}, 32'd1);
            if (mem_en) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4", "unexpected operation", {15'd0, mem_we, mem_addr, mem_wdata}, 32'd0);
                end else begin
                    op_t e;
                    e = expq.pop_front();
                    check(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
                          "R4", "operation", {15'd0, mem_we, mem_addr, mem_wdata},
                          {15'd0, e.we, e.addr, e.data});
                end
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // driver: predicts the operation stream from the element code
    task automatic predict(input logic [2:0] code, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] bg, output int nops, output int bad_k,
                           output logic [7:0] fa, output logic [7:0] fd);
        int  elem;
        int  per;
        bit  stop_now;
        elem     = int'(code[1:0]);
        per      = (elem == 1 || elem == 2) ? 2 : 1;
        nops     = 0;
        bad_k    = -1;
        fa       = 8'h00;
        fd       = 8'h00;
        stop_now = 1'b0;
        for (int i = 0; i <= int'(hi) - int'(lo); i++) begin
            logic [7:0] a;
            a = code[2] ? hi - 8'(i) : lo + 8'(i);
            for (int j = 0; j < per; j++) begin
                bit         we;
                bit         inv;
                logic [7:0] d;
                op_t        o;
                if (bad_k >= 0 && nops > bad_k + 1) stop_now = 1'b1;
                if (stop_now) break;
                we  = (elem == 0) || (j == 1);
                inv = (elem == 1 && j == 1) || (elem == 2 && j == 0);
                d   = inv ? ~bg : bg;
                o.we = we; o.addr = a; o.data = d;
                expq.push_back(o);
                if (we) begin
                    pmem[a] = d;
                end else if (bad_k < 0) begin
                    logic [7:0] got;
                    got = pmem[a] | ((flt_on && a == flt_addr) ? flt_mask : 8'h00);
                    if (got != d) begin bad_k = nops; fa = a; fd = got; end
                end
                nops++;
            end
            if (stop_now) break;
        end
    endtask

    task automatic run_elem(input logic [2:0] code, input logic [7:0] lo, input logic [7:0] hi,
                            input logic [7:0] bg, input bit poke, input string tag);
        int          nops;
        int          bad_k;
        int          busy_n;
        bit          fin;
        logic [7:0]  fa;
        logic [7:0]  fd;
        logic [7:0]  first_sts;
        logic [15:0] v;
        bus_write(3'd0, {8'h00, bg});
        bus_write(3'd1, {8'h00, lo});
        bus_write(3'd2, {8'h00, hi});
        bus_write(3'd3, {13'd0, code});
        predict(code, lo, hi, bg, nops, bad_k, fa, fd);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0001;
        @(posedge clk);
        busy_n    = 0;
        fin       = 1'b0;
        first_sts = 8'h00;
        while (!fin) begin
            @(negedge clk);
            if (poke && busy_n == 3) begin
                bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = {8'h00, ~bg};
                busy_n++;
            end else if (poke && busy_n == 4) begin
                bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0001;
                busy_n++;
            end else begin
                bus_wr = 1'b0; bus_addr = 3'd5;
                #1;
                if (busy_n == 0) first_sts = bus_rdata[7:0];
                if (bus_rdata[7:0] == 8'h0F && busy_n < 5000) busy_n++;
                else fin = 1'b1;
            end
        end
        check(first_sts == 8'h0F, "R7", {tag, " busy status"}, first_sts, 8'h0F);
        if (bad_k < 0) begin
            check(bus_rdata[7:0] == 8'hFF, "R6", {tag, " pass status"}, bus_rdata[7:0], 8'hFF);
            check(busy_n == nops + 1, "R6", {tag, " cycles to pass"}, busy_n, nops + 1);
            bus_read(3'd6, v);
            check(v == 16'h0000, "R8", {tag, " fail address cleared"}, v, 0);
        end else begin
            check(bus_rdata[7:0] == 8'h01, "R5", {tag, " fail status"}, bus_rdata[7:0], 8'h01);
            check(busy_n == bad_k + 2, "R5", {tag, " cycles to fail"}, busy_n, bad_k + 2);
            bus_read(3'd6, v);
            check(v == {8'h00, fa}, "R5", {tag, " fail address"}, v, fa);
            bus_read(3'd7, v);
            check(v == {8'h00, fd}, "R5", {tag, " fail data"}, v, fd);
        end
        check(expq.size() == 0, "R4", {tag, " operations left"}, expq.size(), 0);
        expq.delete();
        if (poke) begin
            bus_read(3'd0, v);
            check(v == {8'h00, bg}, "R8", {tag, " write while busy ignored"}, v, bg);
        end
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 16'h0;
        flt_on = 1'b0; flt_addr = 8'h00; flt_mask = 8'h00;
        for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; pmem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(3'd5, v);
        check(v == 16'h0000, "R1", "reset status", v, 0);
        check(mem_en == 1'b0, "R1", "reset mem_en", {31'd0, mem_en}, 0);
        bus_read(3'd0, v);
        check(v == 16'h0000, "R1", "reset background", v, 0);

        // R2: register readback
        bus_write(3'd0, 16'h003C);
        bus_write(3'd1, 16'h0002);
        bus_write(3'd2, 16'h000B);
        bus_write(3'd3, 16'h0005);
        bus_read(3'd0, v); check(v == 16'h003C, "R2", "background readback", v, 16'h3C);
        bus_read(3'd1, v); check(v == 16'h0002, "R2", "lower bound readback", v, 2);
        bus_read(3'd2, v); check(v == 16'h000B, "R2", "upper bound readback", v, 16'hB);
        bus_read(3'd3, v); check(v == 16'h0005, "R2", "code readback", v, 5);

        // R3 R9: full March C- from software, background 0x55
        run_elem(3'd0, 8'd0, 8'd15, 8'h55, 1'b0, "R3 w0 up");
        run_elem(3'd1, 8'd0, 8'd15, 8'h55, 1'b0, "R3 r0w1 up");
        run_elem(3'd2, 8'd0, 8'd15, 8'h55, 1'b0, "R3 r1w0 up");
        run_elem(3'd5, 8'd0, 8'd15, 8'h55, 1'b0, "R9 r0w1 down");
        run_elem(3'd6, 8'd0, 8'd15, 8'h55, 1'b0, "R9 r1w0 down");
        run_elem(3'd3, 8'd0, 8'd15, 8'h55, 1'b0, "R3 r0 up");

        // partial range descending, single-address range, other background
        run_elem(3'd7, 8'd3, 8'd9, 8'h55, 1'b0, "R9 r0 down partial");
        run_elem(3'd4, 8'd5, 8'd5, 8'h0F, 1'b0, "R4 w0 single address");
        run_elem(3'd1, 8'd5, 8'd5, 8'h0F, 1'b0, "R4 r0w1 single address");

        // R5: stuck-at-1 on bit 2 of address 6
        flt_on = 1'b1; flt_addr = 8'd6; flt_mask = 8'h04;
        run_elem(3'd0, 8'd0, 8'd15, 8'h55, 1'b0, "R5 w0");
        run_elem(3'd1, 8'd0, 8'd15, 8'h55, 1'b0, "R5 r0w1");
        run_elem(3'd2, 8'd0, 8'd15, 8'h55, 1'b0, "R5 r1w0 detects");

        // R8: restart clears failure registers; writes while busy ignored
        flt_on = 1'b0;
        run_elem(3'd0, 8'd0, 8'd15, 8'h55, 1'b0, "R8 restart");
        run_elem(3'd3, 8'd0, 8'd15, 8'h55, 1'b1, "R8 poke while busy");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule